// File: doc/BRIEF.md
# Protected Control Register Unlock Sequencer

This block guards a byte-wide control register that sits behind a serial slave port. The bus front end has already decoded bits and framing. It hands this block one event per transaction: a register write, carrying the data byte and the number of data bytes seen between start and stop, or a register read. Two volatile latches, a write-enable latch and an arm latch, record how far a master has got through a fixed unlock sequence. The persistent fields, two watchdog-select bits and three block-protect bits, change only when a commit byte arrives with both latches set.

A commit that changes the persistent fields starts a busy interval. This interval stands in for the slow nonvolatile programming time. It is counted in clock cycles by a down-counter, and while it runs every write is refused. A separate pulse tells the block that a write to a protected memory block was attempted, and this disarms the sequence. Every write or read event gets exactly one ACK/NACK response on the next cycle. The register contents are visible at all times.

Top module: `ctl_unlock_seq`

## Requirements
- R1: After reset the register view `reg_q` reads 00h, `busy` is low and no response is pending.
- R2: A single-byte write of 02h sets the write-enable bit, which is bit 1 of `reg_q`. The write is answered with ACK and does not raise `busy`.
- R3: A single-byte write of 06h while the write-enable bit is set also sets the arm bit, which is bit 2 of `reg_q`. The same write while the write-enable bit is clear changes nothing and is answered with ACK.
- R4: With both latches set, a single-byte write whose bit 7 is 0, bit 1 is 1 and bit 2 is 0 is a commit. It copies data bits 6, 5, 4, 3 and 0 into the same positions of `reg_q`, clears the arm bit, keeps the write-enable bit, and holds `busy` high for exactly BUSY_CYCLES cycles.
- R5: A commit-shaped byte with bit 2 set changes no persistent bit, leaves the arm bit set and does not raise `busy`.
- R6: A commit-shaped byte written while either latch is clear is ignored and answered with ACK. Other bytes that match no step of the sequence are treated the same way.
- R7: A write whose byte count is not exactly 1 is answered with NACK and changes no state.
- R8: Any write that arrives while `busy` is high is answered with NACK and changes no state.
- R9: A read is answered with ACK and never changes `reg_q`, even while `busy` is high.
- R10: A pulse on `prot_hit` clears the arm bit, leaves every other bit unchanged and produces no response.
- R11: `resp_valid` is high for exactly the one cycle after each write or read event. `resp_ack` carries 1 for ACK and 0 for NACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, acts as power-on |
| wr_valid | input | 1 | One-cycle pulse: a register write transaction has ended |
| wr_data | input | 8 | First data byte of the write |
| wr_count | input | COUNT_W | Number of data bytes in the write |
| rd_valid | input | 1 | One-cycle pulse: a register read transaction has ended |
| prot_hit | input | 1 | One-cycle pulse: a write to a protected block was attempted |
| reg_q | output | 8 | Register view {0, wd[1:0], bp2, bp1, arm, wel, bp0} |
| resp_valid | output | 1 | Response strobe |
| resp_ack | output | 1 | 1 = ACK, 0 = NACK |
| busy | output | 1 | Programming interval in progress |

## Verification
Every event is registered once. `reg_q`, `resp_valid` and `resp_ack` therefore change at the first rising edge after the input pulse, and the bench reads them at the falling edge that follows. `busy` rises at the same edge as the commit. It is counted sample by sample until it falls, and the count must equal BUSY_CYCLES. Writes and reads are placed inside that window to see the refusal. Inputs change only on falling edges, so each result falls exactly one sample after its stimulus.

// File: rtl/ctl_unlock_pkg.sv
package ctl_unlock_pkg;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_READ,
    OP_ABORT,
    OP_BUSY,
    OP_SET_WEL,
    OP_ARM,
    OP_COMMIT,
    OP_REARM,
    OP_IGNORE
  } op_e;

  typedef struct packed {
    logic [1:0] wd;
    logic [2:0] bp;
  } nv_t;

  localparam logic [7:0] KEY_WEL = 8'h02;
  localparam logic [7:0] KEY_ARM = 8'h06;

  // byte looks like a commit: top bit clear, bit 1 set
  function automatic logic commit_shape(input logic [7:0] d);
    return (d[7] == 1'b0) && (d[1] == 1'b1);
  endfunction

  // bit 2 set in a commit means re-arm only
  function automatic logic commit_rearms(input logic [7:0] d);
    return d[2];
  endfunction

  function automatic nv_t extract_nv(input logic [7:0] d);
    nv_t n;
    n.wd = d[6:5];
    n.bp = {d[4], d[3], d[0]};
    return n;
  endfunction

  function automatic logic [7:0] pack_view(input nv_t n, input logic rwel, input logic wel);
    return {1'b0, n.wd, n.bp[2], n.bp[1], rwel, wel, n.bp[0]};
  endfunction

  function automatic logic op_is_nack(input op_e op);
    return (op == OP_ABORT) || (op == OP_BUSY);
  endfunction

endpackage

// File: rtl/ctl_cmd_decode.sv
module ctl_cmd_decode
  import ctl_unlock_pkg::*;
#(
  parameter int COUNT_W = 4
) (
  input  logic               wr_valid,
  input  logic               rd_valid,
  input  logic [7:0]         wr_data,
  input  logic [COUNT_W-1:0] wr_count,
  input  logic               wel,
  input  logic               rwel,
  input  logic               busy,
  output op_e                op
);

  localparam logic [COUNT_W-1:0] ONE_BYTE = COUNT_W'(1);

  logic single_byte;
  logic armed;

  assign single_byte = (wr_count == ONE_BYTE);
  assign armed       = wel && rwel;

  always_comb begin
    op = OP_NONE;
    if (wr_valid) begin
      if (busy) begin
        op = OP_BUSY;
      end else if (!single_byte) begin
        op = OP_ABORT;
      end else if (armed && commit_shape(wr_data)) begin
        op = commit_rearms(wr_data) ? OP_REARM : OP_COMMIT;
      end else if (wr_data == KEY_WEL) begin
        op = OP_SET_WEL;
      end else if ((wr_data == KEY_ARM) && wel) begin
        op = OP_ARM;
      end else begin
        op = OP_IGNORE;
      end
    end else if (rd_valid) begin
      op = OP_READ;
    end
  end

  // R6: without both latches no commit may be decoded
  always_comb begin
    if (!armed) begin
      assert_no_commit_unarmed_R6: assert ((op != OP_COMMIT) && (op != OP_REARM))
        else $error("commit decoded while not armed");
    end
  end

endmodule

// File: rtl/ctl_latch_regs.sv
module ctl_latch_regs
  import ctl_unlock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  op_e        op,
  input  logic [7:0] wr_data,
  input  logic       prot_hit,
  output logic       wel,
  output logic       rwel,
  output nv_t        nv,
  output logic       commit_fire
);

  logic wel_q, rwel_q;
  logic wel_d, rwel_d;
  nv_t  nv_q, nv_d;

  assign commit_fire = (op == OP_COMMIT);

  always_comb begin
    wel_d  = wel_q;
    rwel_d = rwel_q;
    nv_d   = nv_q;
    case (op)
      OP_SET_WEL: wel_d = 1'b1;
      OP_ARM: begin
        wel_d  = 1'b1;
        rwel_d = 1'b1;
      end
      OP_COMMIT: begin
        nv_d   = extract_nv(wr_data);
        rwel_d = 1'b0;
      end
      default: ;
    endcase
    if (prot_hit) rwel_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      rwel_q <= 1'b0;
      nv_q   <= '0;
    end else begin
      wel_q  <= wel_d;
      rwel_q <= rwel_d;
      nv_q   <= nv_d;
    end
  end

  assign wel  = wel_q;
  assign rwel = rwel_q;
  assign nv   = nv_q;

  // R3: arm latch can only rise when write-enable was already set
  assert_arm_needs_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rwel_q) |-> $past(wel_q))
    else $error("arm latch set without write enable");

  // R4: persistent fields move only on a commit
  assert_nv_only_on_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_fire |=> $stable(nv_q))
    else $error("persistent bits changed without commit");

  // R10: protect violation disarms
  assert_prot_clears_arm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    prot_hit |=> !rwel_q)
    else $error("arm latch survived protect violation");

endmodule

// File: rtl/ctl_busy_timer.sv
module ctl_busy_timer #(
  parameter int BUSY_CYCLES = 2_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int CNT_W = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(BUSY_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c, input logic ld);
    if (ld) return LOAD_VAL;
    if (c != '0) return c - 1'b1;
    return c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= next_count(cnt_q, start);
  end

  assign busy = (cnt_q != '0);

  // R4: a commit always opens the busy window
  assert_busy_after_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy)
    else $error("busy not raised after commit");

  // R5: without a commit an idle timer stays idle
  assert_idle_stays_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy)
    else $error("busy rose without commit");

endmodule

// File: rtl/ctl_unlock_seq.sv
module ctl_unlock_seq
  import ctl_unlock_pkg::*;
#(
  parameter int BUSY_CYCLES = 2_000_000,
  parameter int COUNT_W     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  input  logic [7:0]         wr_data,
  input  logic [COUNT_W-1:0] wr_count,
  input  logic               rd_valid,
  input  logic               prot_hit,
  output logic [7:0]         reg_q,
  output logic               resp_valid,
  output logic               resp_ack,
  output logic               busy
);

  op_e  op;
  logic wel, rwel;
  nv_t  nv;
  logic commit_fire;
  logic event_seen;
  logic resp_valid_q, resp_ack_q;

  ctl_cmd_decode #(.COUNT_W(COUNT_W)) u_decode (
    .wr_valid (wr_valid),
    .rd_valid (rd_valid),
    .wr_data  (wr_data),
    .wr_count (wr_count),
    .wel      (wel),
    .rwel     (rwel),
    .busy     (busy),
    .op       (op)
  );

  ctl_latch_regs u_latches (
    .clk         (clk),
    .rst_n       (rst_n),
    .op          (op),
    .wr_data     (wr_data),
    .prot_hit    (prot_hit),
    .wel         (wel),
    .rwel        (rwel),
    .nv          (nv),
    .commit_fire (commit_fire)
  );

  ctl_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (commit_fire),
    .busy  (busy)
  );

  assign event_seen = (op != OP_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid_q <= 1'b0;
      resp_ack_q   <= 1'b0;
    end else begin
      resp_valid_q <= event_seen;
      resp_ack_q   <= event_seen && !op_is_nack(op);
    end
  end

  assign reg_q      = pack_view(nv, rwel, wel);
  assign resp_valid = resp_valid_q;
  assign resp_ack   = resp_ack_q;

  // R7: a multi-byte or empty write is refused
  assert_multibyte_nack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && (wr_count != COUNT_W'(1))) |=> (resp_valid && !resp_ack))
    else $error("multi-byte write not refused");

  // R8: writes during busy are refused and leave the view alone
  assert_busy_write_nack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && busy) |=> (resp_valid && !resp_ack))
    else $error("write during busy not refused");

  assert_busy_write_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && busy && !prot_hit) |=> $stable(reg_q))
    else $error("write during busy changed state");

  // R9: a read never touches the register
  assert_read_no_effect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !wr_valid && !prot_hit) |=> ($stable(reg_q) && resp_ack))
    else $error("read disturbed register");

  // R11: one response per event, none otherwise
  assert_resp_follows_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid || rd_valid) |=> resp_valid)
    else $error("missing response");

  assert_no_spurious_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid || rd_valid) |=> !resp_valid)
    else $error("spurious response");

endmodule

// File: tb/ctl_unlock_seq_tb.sv
module ctl_unlock_seq_tb;

  localparam int BUSY = 16;
  localparam int CW   = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [7:0]    wr_data = 8'h00;
  logic [CW-1:0] wr_count = '0;
  logic          rd_valid = 1'b0;
  logic          prot_hit = 1'b0;
  logic [7:0]    reg_q;
  logic          resp_valid, resp_ack, busy;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  ctl_unlock_seq #(.BUSY_CYCLES(BUSY), .COUNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_count(wr_count), .rd_valid(rd_valid), .prot_hit(prot_hit),
    .reg_q(reg_q), .resp_valid(resp_valid), .resp_ack(resp_ack), .busy(busy)
  );

  // kind: 0 write, 1 read, 2 protect pulse
  // {kind[1:0], data[7:0], count[3:0], exp_reg[7:0], exp_ack}
  localparam int NV = 14;
  localparam logic [22:0] VEC [NV] = '{
    {2'd0, 8'h06, 4'd1, 8'h00, 1'b1},  // R3 06h without WEL ignored
    {2'd0, 8'h62, 4'd1, 8'h00, 1'b1},  // R6 commit shape, latches clear
    {2'd0, 8'h02, 4'd1, 8'h02, 1'b1},  // R2 set WEL
    {2'd1, 8'h00, 4'd0, 8'h02, 1'b1},  // R9 read
    {2'd0, 8'h06, 4'd1, 8'h06, 1'b1},  // R3 arm
    {2'd0, 8'h7B, 4'd1, 8'h7B, 1'b1},  // R4 commit all ones
    {2'd0, 8'h06, 4'd1, 8'h7F, 1'b1},  // R3 re-arm after commit
    {2'd0, 8'h06, 4'd1, 8'h7F, 1'b1},  // R5 commit with bit 2 set
    {2'd0, 8'h06, 4'd2, 8'h7F, 1'b0},  // R7 two bytes
    {2'd0, 8'h02, 4'd1, 8'h02, 1'b1},  // R4 commit clears all fields
    {2'd0, 8'h06, 4'd1, 8'h06, 1'b1},  // R3 arm again
    {2'd2, 8'h00, 4'd0, 8'h02, 1'b0},  // R10 protect pulse disarms
    {2'd0, 8'h46, 4'd1, 8'h02, 1'b1},  // R6 unmatched byte ignored
    {2'd0, 8'h06, 4'd0, 8'h02, 1'b0}   // R7 zero bytes
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive at a falling edge, release at the next one; outputs are then one edge old
  task automatic run_op(input logic [1:0] kind, input logic [7:0] d, input logic [CW-1:0] c);
    @(negedge clk);
    wr_valid = (kind == 2'd0);
    rd_valid = (kind == 2'd1);
    prot_hit = (kind == 2'd2);
    wr_data  = d;
    wr_count = c;
    @(negedge clk);
    wr_valid = 1'b0;
    rd_valid = 1'b0;
    prot_hit = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset reg_q", reg_q, 8'h00);
    chk("R1", "reset busy", busy, 0);
    chk("R1", "reset resp_valid", resp_valid, 0);

    for (int i = 0; i < NV; i++) begin
      wait_idle();
      run_op(VEC[i][22:21], VEC[i][20:13], VEC[i][12:9]);
      chk("vector", $sformatf("step %0d reg_q", i), reg_q, VEC[i][8:1]);
      if (VEC[i][22:21] == 2'd2) begin
        chk("R10", "no response to protect pulse", resp_valid, 0);
      end else begin
        chk("R11", $sformatf("step %0d resp_valid", i), resp_valid, 1);
        chk("R11", $sformatf("step %0d resp_ack", i), resp_ack, VEC[i][0]);
      end
    end

    // R11: response lasts one cycle
    @(negedge clk);
    chk("R11", "response drops", resp_valid, 0);

    // R4: busy window length, from state WEL=1
    wait_idle();
    run_op(2'd0, 8'h06, 4'd1);
    chk("R3", "arm before timing", reg_q, 8'h06);
    chk("R2", "no busy after volatile write", busy, 0);
    run_op(2'd0, 8'h23, 4'd1);
    chk("R4", "commit value", reg_q, 8'h23);
    begin
      int n;
      n = 0;
      while (busy && n < 1000) begin
        n++;
        @(negedge clk);
      end
      chk("R4", "busy cycles", n, BUSY);
    end

    // R8 / R9: writes refused and reads served while busy
    run_op(2'd0, 8'h06, 4'd1);
    chk("R3", "arm for second commit", reg_q, 8'h27);
    run_op(2'd0, 8'h02, 4'd1);
    chk("R4", "second commit clears fields", reg_q, 8'h02);
    chk("R4", "busy raised", busy, 1);
    run_op(2'd0, 8'h06, 4'd1);
    chk("R8", "busy write nack", resp_ack, 0);
    chk("R8", "busy write no change", reg_q, 8'h02);
    run_op(2'd1, 8'h00, 4'd0);
    chk("R9", "busy read ack", resp_ack, 1);
    chk("R9", "busy read no change", reg_q, 8'h02);
    wait_idle();
    run_op(2'd0, 8'h06, 4'd1);
    chk("R8", "write accepted after busy", resp_ack, 1);
    chk("R3", "arm after busy", reg_q, 8'h06);

    // R1: reset clears the arm latch and everything else
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "reset clears view", reg_q, 8'h00);
    chk("R1", "reset clears busy", busy, 0);
    rst_n = 1'b1;
    run_op(2'd0, 8'h06, 4'd1);
    chk("R3", "06h after reset ignored", reg_q, 8'h00);

    finish_run();
  end

endmodule